// File: doc/BRIEF.md
# Cascadable Serial LED Sink Controller

This block is a clocked model of the digital core of a sixteen-channel constant-current LED sink driver. A host sends a bit stream on a serial data pin together with a slow shift clock. The block samples the shift clock on its own system clock, and each rising transition of the shift clock pushes one bit into a sixteen-stage register. The last stage of that register drives a serial output, so any number of these blocks can be chained: the serial output of one block feeds the serial data input of the next.

A level-sensitive load strobe makes the output latches transparent to the register. While the strobe is high, the latches follow the register. When it drops, they keep their value. An active-low enable gates the latches onto sixteen channel-on signals.

Two protection flags blank the channels:
- **Undervoltage flag.** It blanks the channels and wipes both the register and the latches. Operation resumes from all-zero state when the flag drops.
- **Over-temperature flag.** It is derived from an 8-bit temperature code in whole degrees. The flag trips above an upper threshold and releases only at or below a lower one. While it is set, shifting and latching keep working, and no data is lost.

Top module: `led_sink_ctrl`

## Requirements
- R1: After reset, all register stages and all latch bits are 0, `sdout` is 0 and every `chan_on` bit is 0.
- R2: On each low-to-high transition of `sclk` (seen on `clk`), `sdin` enters stage 0 and every stage moves one place toward stage 15. `sdout` always equals stage 15, so a bit reaches `sdout` after 16 transitions.
- R3: `sclk` held at a steady level, high or low, causes no shift regardless of `sdin`.
- R4: While `le` is 1, the latches equal the register in the same cycle in which a shift becomes visible.
- R5: While `le` is 0, the latches keep their value through any number of shifts.
- R6: With `oe_n` = 1, every `chan_on` bit is 0. With `oe_n` = 0 and no protection active, `chan_on[i]` equals latch bit i.
- R7: The level of `oe_n` never alters the register or the latches.
- R8: While `uv` is 1, every `chan_on` bit is 0.
- R9: When `uv` returns to 0, the register and the latches are both 0, and operation resumes normally.
- R10: The thermal blank sets one clock after `temp_c` is strictly greater than `TRIP_C` (default 165). From then on, every `chan_on` bit is 0.
- R11: The thermal blank clears one clock after `temp_c` is at or below `RELEASE_C` (default 150). For codes between the two thresholds, the previous state is kept.
- R12: During thermal blanking, shifting and latching still take effect. The data latched during blanking appears on the channels after release.
- R13: With `le` held at 1 and `oe_n` at 0, `chan_on` tracks the register after every shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| sclk | input | 1 | Serial shift clock, sampled on `clk` |
| sdin | input | 1 | Serial data input |
| le | input | 1 | Latch load strobe, level-transparent when 1 |
| oe_n | input | 1 | Active-low channel enable |
| uv | input | 1 | Undervoltage flag, active high |
| temp_c | input | 8 | Temperature code, unsigned whole degrees |
| sdout | output | 1 | Serial data output, the last register stage |
| chan_on | output | 16 | Channel-on signals |

## Verification
The hardest case to reach from the ports is the middle band of the thermal hysteresis. There, the same temperature code must blank the channels on the way down and leave them lit on the way up. The bench sweeps the code upward across the whole band and then downward. At every step it compares the channels against its own two-threshold model, and it keeps a known pattern latched so that the blanking is visible. A second awkward case is data loaded while the channels are blanked. The bench shifts and latches a new word during thermal blanking and then checks that this word, not the earlier one, lights up after release.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  // Shift one bit into the low end of a register.
  function automatic logic [15:0] push_bit(input logic [15:0] cur, input logic b);
    return {cur[14:0], b};
  endfunction

  // Two-threshold hysteresis step for the thermal blank flag.
  function automatic logic therm_step(input logic hot, input int unsigned t,
                                      input int unsigned trip, input int unsigned rel);
    if (hot) return (t > rel);
    else     return (t > trip);
  endfunction
endpackage

// File: rtl/lsc_shift.sv
module lsc_shift #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic         din,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (step)  q <= {q[N-2:0], din};
  end
endmodule

// File: rtl/lsc_latch.sv
module lsc_latch #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         le,
  input  logic [N-1:0] d,
  output logic [N-1:0] held,
  output logic [N-1:0] view
);
  // Transparent while le is high, holding otherwise.
  always_comb begin
    if (clr)     view = '0;
    else if (le) view = d;
    else         view = held;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= view;
  end
endmodule

// File: rtl/lsc_thermal.sv
module lsc_thermal #(
  parameter int          TW        = 8,
  parameter int unsigned TRIP_C    = 165,
  parameter int unsigned RELEASE_C = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] temp_c,
  output logic          hot
);
  import lsc_pkg::*;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot <= 1'b0;
    else        hot <= therm_step(hot, 32'(temp_c), TRIP_C, RELEASE_C);
  end
endmodule

// File: rtl/led_sink_ctrl.sv
module led_sink_ctrl #(
  parameter int          NCH       = 16,
  parameter int          TW        = 8,
  parameter int unsigned TRIP_C    = 165,
  parameter int unsigned RELEASE_C = 150
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk,
  input  logic           sdin,
  input  logic           le,
  input  logic           oe_n,
  input  logic           uv,
  input  logic [TW-1:0]  temp_c,
  output logic           sdout,
  output logic [NCH-1:0] chan_on
);
  localparam int LAST = NCH - 1;

  logic           sclk_q;
  logic           shift_step;
  logic [NCH-1:0] sr_q;
  logic [NCH-1:0] lat_q;
  logic [NCH-1:0] lat_view;
  logic           therm_hot;
  logic           drive_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign shift_step = sclk & ~sclk_q;

  lsc_shift #(.N(NCH)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(uv), .step(shift_step), .din(sdin), .q(sr_q)
  );

  lsc_latch #(.N(NCH)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr(uv), .le(le), .d(sr_q), .held(lat_q), .view(lat_view)
  );

  lsc_thermal #(.TW(TW), .TRIP_C(TRIP_C), .RELEASE_C(RELEASE_C)) u_therm (
    .clk(clk), .rst_n(rst_n), .temp_c(temp_c), .hot(therm_hot)
  );

  assign drive_en = ~oe_n & ~uv & ~therm_hot;
  assign sdout    = sr_q[LAST];

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign chan_on[i] = lat_view[i] & drive_en;
  end
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int          NCH       = 16,
  parameter int          TW        = 8,
  parameter int unsigned RELEASE_C = 150,
  parameter int unsigned TRIP_C    = 165
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sdin,
  input logic           le,
  input logic           oe_n,
  input logic           uv,
  input logic [TW-1:0]  temp_c,
  input logic [NCH-1:0] chan_on,
  input logic [NCH-1:0] sr_q,
  input logic [NCH-1:0] lat_q,
  input logic           shift_step,
  input logic           therm_hot
);
  assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_step && !uv) |=> (sr_q[0] == $past(sdin)));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !uv) |=> (lat_q == $past(lat_q)));

  assert_oe_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (chan_on == '0));

  assert_uv_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    uv |-> (chan_on == '0));

  assert_uv_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uv) |-> (sr_q == '0 && lat_q == '0));

  assert_hot_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    therm_hot |-> (chan_on == '0));

  assert_hot_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_hot && (32'(temp_c) > RELEASE_C)) |=> therm_hot);

  assert_cool_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!therm_hot && (32'(temp_c) <= TRIP_C)) |=> !therm_hot);
endmodule

bind led_sink_ctrl lsc_checker #(
  .NCH(NCH), .TW(TW), .RELEASE_C(RELEASE_C), .TRIP_C(TRIP_C)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sdin(sdin), .le(le), .oe_n(oe_n), .uv(uv),
  .temp_c(temp_c), .chan_on(chan_on), .sr_q(sr_q), .lat_q(lat_q),
  .shift_step(shift_step), .therm_hot(therm_hot)
);

// File: tb/led_sink_ctrl_tb.sv
module led_sink_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, sdin = 1'b0, le = 1'b0, oe_n = 1'b1, uv = 1'b0;
  logic [7:0]  temp_c = 8'd25;
  logic        sdout;
  logic [15:0] chan_on;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_sh = '0, m_lat = '0;
  logic        m_hot = 1'b0;

  always #10 clk = ~clk;

  led_sink_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .le(le), .oe_n(oe_n),
    .uv(uv), .temp_c(temp_c), .sdout(sdout), .chan_on(chan_on)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); sdin = b; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
    m_sh = {m_sh[14:0], b};
    if (le) m_lat = m_sh;
  endtask

  task automatic pulse_le();
    @(negedge clk); le = 1'b1;
    @(negedge clk); le = 1'b0;
    m_lat = m_sh;
  endtask

  task automatic set_temp(input logic [7:0] t);
    @(negedge clk); temp_c = t;
    m_hot = m_hot ? (t > 8'd150) : (t > 8'd165);
    @(negedge clk);
  endtask

  function automatic logic [15:0] word_of(input int i);
    return 16'(i * 40503 + 12345) ^ 16'(i << 7);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 chan after reset", chan_on, 16'h0);
    check("R1 sdout after reset", {15'b0, sdout}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    oe_n = 1'b0;
    @(negedge clk);
    check("R1 latches zero", chan_on, 16'h0);

    // Word sweep: load with le low, check serial output and hold.
    for (int w = 0; w < 24; w++) begin
      logic [15:0] word;
      word = word_of(w);
      for (int b = 15; b >= 0; b--) begin
        shift_bit(word[b]);
        check("R2 sdout stage15", {15'b0, sdout}, {15'b0, m_sh[15]});
        if (b == 8) check("R5 hold during shift", chan_on, m_lat);
      end
      pulse_le();
      check("R4 latch load", chan_on, word);
    end

    // Steady sclk: no shift.
    @(negedge clk); sclk = 1'b1; sdin = ~m_sh[15];
    @(negedge clk); m_sh = {m_sh[14:0], sdin};
    repeat (6) begin @(negedge clk); sdin = ~sdin; end
    sclk = 1'b0;
    repeat (4) begin @(negedge clk); sdin = ~sdin; end
    pulse_le();
    check("R3 steady sclk no shift", chan_on, m_sh);

    // oe_n gating and no effect on contents.
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk);
    check("R6 oe high blanks", chan_on, 16'h0);
    shift_bit(1'b1); shift_bit(1'b0);
    @(negedge clk); oe_n = 1'b0;
    @(negedge clk);
    check("R7 oe leaves latches", chan_on, m_lat);
    le = 1'b1;
    @(negedge clk);
    check("R7 oe leaves register", chan_on, m_sh);
    le = 1'b0; m_lat = m_sh;
    check("R6 chan follows latch", chan_on, m_lat);

    // Bypass mode.
    @(negedge clk); le = 1'b1;
    for (int b = 0; b < 20; b++) begin
      shift_bit(word_of(b + 50)[b % 16]);
      check("R13 bypass tracks", chan_on, m_sh);
      check("R4 transparent", chan_on, m_lat);
    end
    le = 1'b0;

    // Undervoltage.
    @(negedge clk); uv = 1'b1;
    @(negedge clk);
    check("R8 uv blanks", chan_on, 16'h0);
    shift_bit(1'b1);
    @(negedge clk); uv = 1'b0;
    m_sh = '0; m_lat = '0;
    @(negedge clk);
    check("R9 latches cleared", chan_on, 16'h0);
    check("R9 sdout cleared", {15'b0, sdout}, 16'h0);
    pulse_le();
    check("R9 register cleared", chan_on, 16'h0);
    for (int b = 0; b < 16; b++) shift_bit(b[0]);
    pulse_le();
    check("R9 resumes", chan_on, 16'h5555);

    // Thermal sweep, up then down.
    for (int t = 140; t <= 175; t++) begin
      set_temp(8'(t));
      check("R10 thermal up", chan_on, m_hot ? 16'h0 : m_lat);
    end
    // Load new data while blanked.
    for (int b = 15; b >= 0; b--) shift_bit(16'hC3A5 >> b);
    pulse_le();
    check("R12 still blanked", chan_on, 16'h0);
    for (int t = 175; t >= 140; t--) begin
      set_temp(8'(t));
      check("R11 thermal down", chan_on, m_hot ? 16'h0 : m_lat);
    end
    check("R12 new data after release", chan_on, 16'hC3A5);
    set_temp(8'd166);
    check("R10 trip above 165", chan_on, 16'h0);
    set_temp(8'd151);
    check("R11 held at 151", chan_on, 16'h0);
    set_temp(8'd150);
    check("R11 release at 150", chan_on, 16'hC3A5);
    set_temp(8'd165);
    check("R10 no trip at 165", chan_on, 16'hC3A5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule